// File: doc/BRIEF.md
# Page-Program Block-Erase Flash Array Model

This block is a synthesizable model of a flash array organised as blocks of pages. It obeys the physical write rules of flash: an erase returns a whole block to all-ones, and a program can only pull bits from one to zero. A host sends commands on a command port with a valid/ready handshake. Each command carries a 2-bit opcode, a block index and a page index. Page data moves one byte per clock, inbound on a program stream and outbound on a read stream. Each stream has its own valid/ready pair, and the read stream marks its final byte with a last flag.

The array keeps one saturating erase counter and one sticky bad flag for each block. Both are visible on a status port indexed by block number. A command that targets a block marked bad, or that carries a block or page index beyond the geometry, finishes at once with an error status and changes nothing. The geometry is set by parameters: `BLOCKS`, `PAGES` (pages per block) and `PAGE_BYTES`, each a power of two. A production array uses 64 pages of 2048 bytes. The defaults are small so the model stays cheap to elaborate. `ERASE_CYCLES` adds a fixed settling delay before the erase sweep.

The controller is a state machine with these states:
- ST_IDLE: waits for a command.
- ST_READ: streams a page out.
- ST_PROG: accepts a page in.
- ST_EWAIT: waits out the erase delay.
- ST_ESWEEP: writes ones across the block, one byte per cycle.
- ST_DONE: a single cycle that reports completion.

The transitions are:
- ST_IDLE goes to ST_DONE for a rejected command or a bad-block marking. It goes to ST_READ, ST_PROG or ST_EWAIT for an accepted read, program or erase.
- ST_READ and ST_PROG go to ST_DONE after the last byte of the page.
- ST_EWAIT goes to ST_ESWEEP when its delay count expires.
- ST_ESWEEP goes to ST_DONE after the last byte of the block.
- ST_DONE goes to ST_IDLE.

Top module: `flash_emu`

## Requirements
- R1: After reset, every byte reads 0xFF, every erase counter is zero, no block is flagged bad, busy is low and cmd_ready is high.
- R2: A program stores old AND new in each byte of the page, so a bit can never go from 0 back to 1 without an erase.
- R3: A read streams exactly PAGE_BYTES bytes in address order. out_last is high only on byte PAGE_BYTES-1. While out_valid is high and out_ready is low, out_data holds steady.
- R4: An erase sets every byte of the addressed block to 0xFF and leaves other blocks alone. Program and read touch only the addressed page.
- R5: An erase keeps busy high for exactly ERASE_CYCLES + PAGES*PAGE_BYTES + 1 cycles after the accepting edge. A program consumes exactly PAGE_BYTES beats, and then in_ready falls.
- R6: Each completed erase adds one to that block's erase counter. The counter saturates at 2^CNT_W-1 and does not wrap.
- R7: Opcode 3 sets a block's bad flag and completes without error. The flag is sticky. A later read (opcode 0), program (opcode 1) or erase (opcode 2) to that block completes with done_err high after one busy cycle. It moves no stream data and leaves the counter unchanged.
- R8: A block index of BLOCKS or more (any opcode), or a page index of PAGES or more on a read or program, completes with done_err after one busy cycle. Memory, counters and flags are left unchanged.
- R9: cmd_ready is high only while the block is idle, and an accepted command raises busy on the next cycle. done is a single-cycle pulse, and done_err qualifies it.
- R10: The status port returns the erase counter and bad flag of stat_blk combinationally. It returns zeros for an out-of-range index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 mark bad |
| cmd_blk | input | BLK_IW | Block index (one bit wider than needed, so out-of-range values can be expressed) |
| cmd_page | input | PG_IW | Page index within the block (one bit wider than needed) |
| in_valid | input | 1 | Program byte offered |
| in_ready | output | 1 | Program byte accepted when high with in_valid |
| in_data | input | 8 | Program byte |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Read byte taken when high with out_valid |
| out_data | output | 8 | Read byte |
| out_last | output | 1 | Final byte of the page |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was a rejection |
| stat_blk | input | BLK_IW | Block whose status is shown |
| stat_erase_cnt | output | CNT_W | Erase counter of stat_blk |
| stat_bad | output | 1 | Bad flag of stat_blk |

## Verification
The bench reads every page of the small array after reset and after each change. It compares every byte against an arithmetic model, so a design that overwrote instead of ANDing on a program, or that erased only one page, would show wrong bytes. It reprograms the same page with a second pattern and erases one block well past counter saturation, which catches a counter that wraps back to zero. It measures the exact erase latency, and it throttles the read stream to catch data that slips while stalled. It also sends commands with block and page indexes just past the edge and commands to a block marked bad. For those it watches that no stream handshake opens and no counter moves, which a design that checked only one of the two ranges would break.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_MARK  = 2'd3
    } fe_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_PROG,
        ST_EWAIT,
        ST_ESWEEP,
        ST_DONE
    } fe_state_e;

endpackage

// File: rtl/flash_emu_array.sv
module flash_emu_array #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              erase,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    assign rdata = mem[addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[addr] <= erase ? 8'hFF : (mem[addr] & wdata);
        end
    end

    // R2: a program can only clear bits
    a_r2_prog_and: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !erase) |=> mem[$past(addr)] == ($past(rdata) & $past(wdata)));

    // R4: an erase write leaves the byte all ones
    a_r4_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (we && erase) |=> mem[$past(addr)] == 8'hFF);

endmodule

// File: rtl/flash_emu_wear.sv
module flash_emu_wear #(
    parameter int BLOCKS = 4,
    parameter int CNT_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(BLOCKS)-1:0] blk,
    input  logic                      inc_en,
    input  logic                      mark_en,
    output logic                      q_bad,
    input  logic [$clog2(BLOCKS):0]   stat_blk,
    output logic [CNT_W-1:0]          stat_cnt,
    output logic                      stat_bad
);
    localparam int BLK_AW = $clog2(BLOCKS);
    localparam int BLK_IW = BLK_AW + 1;

    logic [CNT_W-1:0] cnt [BLOCKS];
    logic [BLOCKS-1:0] bad;
    logic stat_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) cnt[b] <= '0;
            bad <= '0;
        end else begin
            if (inc_en && cnt[blk] != '1) cnt[blk] <= cnt[blk] + CNT_W'(1);
            if (mark_en) bad[blk] <= 1'b1;
        end
    end

    assign q_bad    = bad[blk];
    assign stat_ok  = stat_blk < BLK_IW'(BLOCKS);
    assign stat_cnt = stat_ok ? cnt[stat_blk[BLK_AW-1:0]] : '0;
    assign stat_bad = stat_ok ? bad[stat_blk[BLK_AW-1:0]] : 1'b0;

    for (genvar g = 0; g < BLOCKS; g++) begin : g_chk
        // R6: a saturated counter stays put
        a_r6_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[g] == '1) |=> (cnt[g] == '1));
        // R7: a bad flag never clears
        a_r7_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            bad[g] |=> bad[g]);
    end

endmodule

// File: rtl/flash_emu_ctrl.sv
module flash_emu_ctrl
    import flash_emu_pkg::*;
#(
    parameter int BLOCKS       = 4,
    parameter int PAGES        = 4,
    parameter int PAGE_BYTES   = 16,
    parameter int ERASE_CYCLES = 40
) (
    input  logic                                               clk,
    input  logic                                               rst_n,
    input  logic                                               cmd_valid,
    output logic                                               cmd_ready,
    input  logic [1:0]                                         cmd_op,
    input  logic [$clog2(BLOCKS):0]                            cmd_blk,
    input  logic [$clog2(PAGES):0]                             cmd_page,
    input  logic                                               in_valid,
    output logic                                               in_ready,
    output logic                                               out_valid,
    input  logic                                               out_ready,
    output logic                                               out_last,
    output logic                                               busy,
    output logic                                               done,
    output logic                                               done_err,
    output logic [$clog2(BLOCKS)+$clog2(PAGES)+$clog2(PAGE_BYTES)-1:0] arr_addr,
    output logic                                               arr_we,
    output logic                                               arr_erase,
    output logic [$clog2(BLOCKS)-1:0]                          wear_blk,
    output logic                                               wear_inc,
    output logic                                               wear_mark,
    input  logic                                               q_bad
);
    localparam int BLK_AW = $clog2(BLOCKS);
    localparam int PG_AW  = $clog2(PAGES);
    localparam int BY_AW  = $clog2(PAGE_BYTES);
    localparam int OFF_W  = PG_AW + BY_AW;
    localparam int BLK_IW = BLK_AW + 1;
    localparam int PG_IW  = PG_AW + 1;
    localparam int WT_W   = $clog2(ERASE_CYCLES + 1);

    fe_state_e state, state_nx;
    fe_op_e    op_in;
    logic [BLK_AW-1:0] cur_blk;
    logic [OFF_W-1:0]  off;
    logic [WT_W-1:0]   wait_cnt;
    logic              err_q;
    logic              fire, blk_ok, pg_ok, need_pg, cmd_err, last_byte;

    assign op_in     = fe_op_e'(cmd_op);
    assign fire      = cmd_valid && (state == ST_IDLE);
    assign blk_ok    = cmd_blk < BLK_IW'(BLOCKS);
    assign pg_ok     = cmd_page < PG_IW'(PAGES);
    assign need_pg   = (op_in == OP_READ) || (op_in == OP_PROG);
    assign cmd_err   = !blk_ok || (need_pg && !pg_ok) || ((op_in != OP_MARK) && q_bad);
    assign last_byte = &off[BY_AW-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (fire) begin
                    if (cmd_err) state_nx = ST_DONE;
                    else begin
                        unique case (op_in)
                            OP_READ:  state_nx = ST_READ;
                            OP_PROG:  state_nx = ST_PROG;
                            OP_ERASE: state_nx = ST_EWAIT;
                            OP_MARK:  state_nx = ST_DONE;
                            default:  state_nx = ST_DONE;
                        endcase
                    end
                end
            end
            ST_READ:   if (out_ready && last_byte) state_nx = ST_DONE;
            ST_PROG:   if (in_valid && last_byte)  state_nx = ST_DONE;
            ST_EWAIT:  if (wait_cnt == WT_W'(ERASE_CYCLES - 1)) state_nx = ST_ESWEEP;
            ST_ESWEEP: if (off == '1) state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_blk  <= '0;
            off      <= '0;
            wait_cnt <= '0;
            err_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (fire) begin
                    cur_blk  <= cmd_blk[BLK_AW-1:0];
                    off      <= {cmd_page[PG_AW-1:0], BY_AW'(0)};
                    wait_cnt <= '0;
                    err_q    <= cmd_err;
                end
                ST_READ:   if (out_ready) off <= off + OFF_W'(1);
                ST_PROG:   if (in_valid)  off <= off + OFF_W'(1);
                ST_EWAIT: begin
                    wait_cnt <= wait_cnt + WT_W'(1);
                    off      <= '0;
                end
                ST_ESWEEP: off <= off + OFF_W'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        busy      = (state != ST_IDLE);
        in_ready  = (state == ST_PROG);
        out_valid = (state == ST_READ);
        out_last  = (state == ST_READ) && last_byte;
        done      = (state == ST_DONE);
        done_err  = (state == ST_DONE) && err_q;
        arr_addr  = {cur_blk, off};
        arr_we    = ((state == ST_PROG) && in_valid) || (state == ST_ESWEEP);
        arr_erase = (state == ST_ESWEEP);
        wear_blk  = (state == ST_IDLE) ? cmd_blk[BLK_AW-1:0] : cur_blk;
        wear_inc  = (state == ST_ESWEEP) && (off == '1);
        wear_mark = fire && !cmd_err && (op_in == OP_MARK);
    end

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: an accepted command makes the block busy
    a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);
    // R8: a rejection follows its command directly
    a_r8_err_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |-> $past(cmd_valid && cmd_ready));

endmodule

// File: rtl/flash_emu.sv
module flash_emu #(
    parameter  int BLOCKS       = 4,
    parameter  int PAGES        = 4,
    parameter  int PAGE_BYTES   = 16,
    parameter  int ERASE_CYCLES = 40,
    parameter  int CNT_W        = 3,
    localparam int BLK_IW       = $clog2(BLOCKS) + 1,
    localparam int PG_IW        = $clog2(PAGES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [BLK_IW-1:0] cmd_blk,
    input  logic [PG_IW-1:0]  cmd_page,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              busy,
    output logic              done,
    output logic              done_err,
    input  logic [BLK_IW-1:0] stat_blk,
    output logic [CNT_W-1:0]  stat_erase_cnt,
    output logic              stat_bad
);
    localparam int BLK_AW = $clog2(BLOCKS);
    localparam int ADDR_W = BLK_AW + $clog2(PAGES) + $clog2(PAGE_BYTES);

    logic [ADDR_W-1:0] arr_addr;
    logic              arr_we, arr_erase;
    logic [7:0]        arr_rdata;
    logic [BLK_AW-1:0] wear_blk;
    logic              wear_inc, wear_mark, q_bad;

    flash_emu_ctrl #(
        .BLOCKS(BLOCKS), .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .cmd_page(cmd_page),
        .in_valid(in_valid), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
        .busy(busy), .done(done), .done_err(done_err),
        .arr_addr(arr_addr), .arr_we(arr_we), .arr_erase(arr_erase),
        .wear_blk(wear_blk), .wear_inc(wear_inc), .wear_mark(wear_mark), .q_bad(q_bad)
    );

    flash_emu_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .addr(arr_addr), .we(arr_we),
        .erase(arr_erase), .wdata(in_data), .rdata(arr_rdata)
    );

    flash_emu_wear #(.BLOCKS(BLOCKS), .CNT_W(CNT_W)) u_wear (
        .clk(clk), .rst_n(rst_n), .blk(wear_blk), .inc_en(wear_inc),
        .mark_en(wear_mark), .q_bad(q_bad), .stat_blk(stat_blk),
        .stat_cnt(stat_erase_cnt), .stat_bad(stat_bad)
    );

    assign out_data = arr_rdata;

    // R3: a stalled read byte holds
    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && out_data == $past(out_data)));

endmodule

// File: tb/test_flash_emu.sv
module test_flash_emu;
    localparam int BL = 4, PG = 4, PB = 16, EC = 40, CW = 3;
    localparam int BLK_BYTES = PG * PB;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, in_valid = 0, out_ready = 0;
    logic [1:0] cmd_op = 0;
    logic [2:0] cmd_blk = 0, cmd_page = 0, stat_blk = 0;
    logic [7:0] in_data = 0;
    logic cmd_ready, in_ready, out_valid, out_last, busy, done, done_err, stat_bad;
    logic [7:0] out_data;
    logic [CW-1:0] stat_erase_cnt;

    int checks = 0, errors = 0, cyc = 0;
    logic [7:0] model [BL*PG*PB];

    always #5 clk = ~clk;

    flash_emu #(.BLOCKS(BL), .PAGES(PG), .PAGE_BYTES(PB), .ERASE_CYCLES(EC), .CNT_W(CW)) i_flash_emu (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_page(cmd_page),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .busy(busy), .done(done), .done_err(done_err),
        .stat_blk(stat_blk), .stat_erase_cnt(stat_erase_cnt), .stat_bad(stat_bad));

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int idx(int b, int p, int i);
        return (b * PG + p) * PB + i;
    endfunction

    function automatic logic [7:0] pat(int b, int p, int i, int sel);
        return 8'((i * 37 + p * 11 + b * 5 + sel * 91) ^ (sel * 8'h5A));
    endfunction

    task automatic issue(input int op, input int b, input int p);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_op = 2'(op); cmd_blk = 3'(b); cmd_page = 3'(p);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    // called at the negedge after the accepting edge; returns busy cycles
    task automatic wait_done(output bit err, output int n, output bit leaked);
        n = 0; leaked = 0;
        while (!done) begin
            if (busy) n++;
            if (in_ready || out_valid) leaked = 1;
            @(negedge clk);
        end
        n++;
        err = done_err;
    endtask

    task automatic prog_page(input int b, input int p, input int sel);
        bit e, lk; int n;
        issue(1, b, p);
        for (int i = 0; i < PB; i++) begin
            if (i % 5 == 3) begin in_valid = 0; @(negedge clk); end
            in_valid = 1; in_data = pat(b, p, i, sel);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            model[idx(b, p, i)] = model[idx(b, p, i)] & pat(b, p, i, sel);
        end
        in_valid = 0;
        chk(!in_ready && done, "R5 program beat count", int'(in_ready), 0);
        wait_done(e, n, lk);
        chk(!e, "R2 program status", int'(e), 0);
    endtask

    task automatic read_page(input int b, input int p, input bit bp);
        bit e, lk, hv; int n, k, i; logic [7:0] hd;
        issue(0, b, p);
        k = 0; i = 0; hv = 0; hd = 0;
        while (i < PB) begin
            out_ready = bp ? (k % 3 != 2) : 1'b1;
            k++;
            if (out_valid && hv) chk(out_data == hd, "R3 stalled byte held", out_data, hd);
            if (out_valid && out_ready) begin
                chk(out_data == model[idx(b, p, i)], "R2/R4 read data", out_data, model[idx(b, p, i)]);
                chk(out_last == (i == PB - 1), "R3 last flag", int'(out_last), int'(i == PB - 1));
                i++; hv = 0;
            end else if (out_valid) begin
                hv = 1; hd = out_data;
            end
            @(negedge clk);
        end
        out_ready = 0;
        wait_done(e, n, lk);
        chk(!e, "R3 read status", int'(e), 0);
    endtask

    task automatic read_all(input bit bp);
        for (int b = 0; b < BL; b++)
            for (int p = 0; p < PG; p++) read_page(b, p, bp);
    endtask

    task automatic erase_blk(input int b, input int expn);
        bit e, lk; int n;
        issue(2, b, 0);
        chk(!cmd_ready, "R9 cmd_ready low while busy", int'(cmd_ready), 0);
        wait_done(e, n, lk);
        chk(!e, "R4 erase status", int'(e), 0);
        chk(n == expn, "R5 erase busy cycles", n, expn);
        @(negedge clk);
        chk(!done, "R9 done single pulse", int'(done), 0);
        for (int i = 0; i < BLK_BYTES; i++) model[b * BLK_BYTES + i] = 8'hFF;
    endtask

    task automatic expect_reject(input int op, input int b, input int p, input string req);
        bit e, lk; int n;
        issue(op, b, p);
        wait_done(e, n, lk);
        chk(e, req, int'(e), 1);
        chk(n == 1 && !lk, req, n, 1);
    endtask

    task automatic stat(input int b, input int cnt, input bit bad, input string req);
        stat_blk = 3'(b);
        #1;
        chk(stat_erase_cnt == CW'(cnt) && stat_bad == bad, req,
            int'(stat_erase_cnt) * 2 + int'(stat_bad), cnt * 2 + int'(bad));
    endtask

    initial begin
        bit e, lk; int n;
        for (int i = 0; i < BL*PG*PB; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && cmd_ready && !done, "R1 idle after reset", int'(busy), 0);
        for (int b = 0; b < BL + 2; b++) stat(b, 0, 0, "R1/R10 status after reset");
        read_all(0);

        // R2 program patterns, then AND with a second pattern
        prog_page(0, 1, 0);
        prog_page(1, 3, 0);
        prog_page(2, 0, 1);
        read_all(0);
        prog_page(0, 1, 1);
        prog_page(2, 0, 0);
        read_all(1);

        // R4/R5/R6 erase of block 0, others untouched
        erase_blk(0, EC + BLK_BYTES + 1);
        stat(0, 1, 0, "R6 count after one erase");
        stat(1, 0, 0, "R6 other counter unchanged");
        read_all(0);

        // R6 saturation on block 3
        for (int k = 1; k <= CMAX + 2; k++) begin
            erase_blk(3, EC + BLK_BYTES + 1);
            stat(3, (k > CMAX) ? CMAX : k, 0, "R6 counter saturation");
        end

        // R7 bad block
        issue(3, 1, 0);
        wait_done(e, n, lk);
        chk(!e, "R7 mark status", int'(e), 0);
        stat(1, 0, 1, "R7 flag set");
        expect_reject(0, 1, 3, "R7 read bad block rejected");
        expect_reject(1, 1, 3, "R7 program bad block rejected");
        expect_reject(2, 1, 0, "R7 erase bad block rejected");
        stat(1, 0, 1, "R7 counter unchanged");
        issue(3, 1, 0);
        wait_done(e, n, lk);
        chk(!e, "R7 remark status", int'(e), 0);
        stat(1, 0, 1, "R7 flag sticky");

        // R8 out of range
        expect_reject(0, BL, 0, "R8 read block out of range");
        expect_reject(0, 2, PG, "R8 read page out of range");
        expect_reject(1, 0, PG, "R8 program page out of range");
        expect_reject(2, BL + 1, 0, "R8 erase block out of range");
        expect_reject(3, 7, 0, "R8 mark block out of range");
        stat(0, 1, 0, "R8 block 0 status unchanged");
        stat(2, 0, 0, "R8 block 2 status unchanged");
        stat(3, CMAX, 0, "R8 block 3 status unchanged");
        for (int b = 0; b < BL; b++)
            if (b != 1)
                for (int p = 0; p < PG; p++) read_page(b, p, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule